// File: doc/BRIEF.md
# Table-Driven DMA Slot Scheduler

This block decides, slot by slot, which DMA channel and which direction (receive or transmit) owns the next transfer opportunity. Software loads a table of one-byte entries through a simple register write port. Each entry names a channel and says whether the slot serves the receive or the transmit side. A control register switches the scheduler on and gives the index of the last valid entry. The current entry is presented as a grant. Each time the data path accepts that grant with an advance strobe, the scheduler steps to the next entry. After the last entry it wraps back to entry 0.

The table is double buffered. Writes land in a shadow copy. The active copy that drives the grant is reloaded from the shadow only when the walk wraps to entry 0, or continuously while the scheduler is off. This means a pass through the table is never a mixture of old and new contents. The usual way to reprogram is to write zero to the control register, load the table, and then enable the scheduler with the new last index. Arbitration among ready channels beyond following the table, and the movement of data, are handled elsewhere.

Top module: `slot_sched`

## Requirements
- R1: After reset the scheduler is off (`grant_valid` = 0), the walk index is 0, and every table byte is 0, so the first grant after enabling without loading the table is channel 0, transmit.
- R2: A write to address 0x000 sets the control register. Bit 31 is the enable and bits 6:0 are the last entry index. `grant_valid` equals the enable from the cycle after the write.
- R3: Table word w is written at address 0x800 + 4·w (w = 0..31). Entry index 4·w + k is byte k, bits 8k+7:8k, of word w. In that byte, bits 6:0 are `grant_chan` and bit 7 is `grant_rx` (1 = receive, 0 = transmit).
- R4: When `grant_valid` and `adv` are both 1 at a clock edge, the index moves by one entry. With `adv` = 0 the grant holds. `adv` while `grant_valid` = 0 has no effect.
- R5: An accepted advance at an index equal to or above the last index wraps the walk to entry 0. With last index 0 the grant stays on entry 0.
- R6: While disabled the index is held at 0 and `grant_valid` is 0. Re-enabling always starts at entry 0.
- R7: A table write made while enabled does not change the grant until the walk wraps to entry 0. From that pass on, the new contents are used.
- R8: Writes to any address other than 0x000 or an aligned word in 0x800..0x87C (misaligned, beyond the table, or elsewhere) change neither the table nor the control register.
- R9: If the last index is lowered below the current index, the next accepted advance wraps to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte address |
| wr_data | input | 32 | Register write data |
| adv | input | 1 | Advance strobe from the data path; accepts the current grant |
| grant_valid | output | 1 | A grant is being presented (scheduler enabled) |
| grant_chan | output | 7 | Channel number of the current entry |
| grant_rx | output | 1 | Direction of the current entry: 1 receive, 0 transmit |

## Verification
A wrong index or a stale active table shows up immediately as a wrong channel or direction on the grant, in the first cycle after the faulty step. The bench keeps its own copy of the shadow table, the active table, the index and the control fields, and compares every output on every cycle.

A missed wrap or a missed reload is visible within one accepted advance of the last entry. A leaked table write (one that reaches the active copy early) is visible as soon as the walk reaches the entry that was written. Directed passes cover the following cases:
- the full 120-entry interleaved layout,
- a last index of 0,
- a last index lowered below the current position,
- disable in mid-walk,
- ignored addresses.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    localparam int WORD_W       = 32;
    localparam int SLOT_W       = 8;
    localparam int SLOTS_PER_WD = WORD_W / SLOT_W;
    localparam int CHAN_W       = SLOT_W - 1;
    localparam int EN_BIT       = 31;

    typedef struct packed {
        logic              rx;
        logic [CHAN_W-1:0] chan;
    } slot_t;
endpackage

// File: rtl/slot_sched_regs.sv
module slot_sched_regs
    import slot_sched_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int ADDR_W    = 12,
    parameter int CTRL_ADDR = 'h000,
    parameter int TBL_BASE  = 'h800,
    localparam int IDX_W    = $clog2(NUM_WORDS * SLOTS_PER_WD),
    localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic                              en,
    output logic [IDX_W-1:0]                  last,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  shadow_nxt
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(TBL_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(NUM_WORDS * 4);

    typedef struct packed {
        logic                             en;
        logic [IDX_W-1:0]                 last;
        logic [NUM_WORDS-1:0][WORD_W-1:0] tbl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [ADDR_W-1:0] ofs;
    logic              tbl_hit;
    logic              ctrl_hit;
    logic [WIDX_W-1:0] widx;

    always_comb begin
        ofs      = wr_addr - BASE_A;
        tbl_hit  = wr_en && (wr_addr >= BASE_A) && (ofs < SPAN_A) && (wr_addr[1:0] == 2'b00);
        ctrl_hit = wr_en && (wr_addr == CTRL_A);
        widx     = ofs[WIDX_W+1:2];
        st_d     = st_q;
        if (ctrl_hit) begin
            st_d.en   = wr_data[EN_BIT];
            st_d.last = wr_data[IDX_W-1:0];
        end
        if (tbl_hit) begin
            st_d.tbl[widx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en         = st_q.en;
    assign last       = st_q.last;
    assign shadow_nxt = st_d.tbl;
endmodule

// File: rtl/slot_sched_index.sv
module slot_sched_index
    import slot_sched_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    localparam int IDX_W    = $clog2(NUM_WORDS * SLOTS_PER_WD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             adv,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] idx,
    output logic             reload
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic       step;
    logic       at_end;

    always_comb begin
        step   = en && adv;
        at_end = (st_q.idx >= last);
        reload = !en || (step && at_end);
        st_d   = st_q;
        if (!en) begin
            st_d.idx = '0;
        end else if (step) begin
            st_d.idx = at_end ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx = st_q.idx;
endmodule

// File: rtl/slot_sched_table.sv
module slot_sched_table
    import slot_sched_pkg::*;
#(
    parameter int NUM_WORDS  = 32,
    localparam int NUM_SLOTS = NUM_WORDS * SLOTS_PER_WD,
    localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reload,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_nxt,
    input  logic [IDX_W-1:0]                 idx,
    output slot_t                            cur,
    output logic [NUM_WORDS*WORD_W-1:0]      act_flat
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] act;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    slot_t      slots [NUM_SLOTS];

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.act = shadow_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar k = 0; k < SLOTS_PER_WD; k++) begin : g_slot
            assign slots[w*SLOTS_PER_WD + k] = slot_t'(st_q.act[w][SLOT_W*k +: SLOT_W]);
        end
    end

    assign cur      = slots[idx];
    assign act_flat = st_q.act;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int NUM_WORDS  = 32,
    parameter int ADDR_W     = 12,
    localparam int NUM_SLOTS = NUM_WORDS * SLOTS_PER_WD,
    localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              adv,
    output logic              grant_valid,
    output logic [6:0]        grant_chan,
    output logic              grant_rx
);
    logic                             en;
    logic [IDX_W-1:0]                 last;
    logic [IDX_W-1:0]                 idx;
    logic                             reload;
    logic [NUM_WORDS-1:0][WORD_W-1:0] shadow_nxt;
    logic [NUM_WORDS*WORD_W-1:0]      act_flat;
    slot_t                            cur;

    slot_sched_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en(en), .last(last), .shadow_nxt(shadow_nxt)
    );

    slot_sched_index #(.NUM_WORDS(NUM_WORDS)) u_index (
        .clk(clk), .rst_n(rst_n), .en(en), .adv(adv), .last(last),
        .idx(idx), .reload(reload)
    );

    slot_sched_table #(.NUM_WORDS(NUM_WORDS)) u_table (
        .clk(clk), .rst_n(rst_n), .reload(reload), .shadow_nxt(shadow_nxt),
        .idx(idx), .cur(cur), .act_flat(act_flat)
    );

    assign grant_valid = en;
    assign grant_chan  = cur.chan;
    assign grant_rx    = cur.rx;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     grant_valid,
    input logic                     adv,
    input logic [IDX_W-1:0]         idx,
    input logic [IDX_W-1:0]         last,
    input logic [NUM_WORDS*32-1:0]  act_flat
);
    AST_OFF_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |=> (idx == '0)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && adv && (idx < last)) |=> (!grant_valid || (idx == $past(idx) + 1'b1))); // R4

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !adv) |=> (!grant_valid || $stable(idx))); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && adv && (idx >= last)) |=> (idx == '0)); // R5

    AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(adv && (idx >= last))) |=> $stable(act_flat)); // R7
endmodule

bind slot_sched slot_sched_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .adv(adv),
    .idx(idx), .last(last), .act_flat(act_flat)
);

// File: tb/slot_sched_test.sv
`timescale 1ns/1ps
module slot_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        adv = 1'b0;
    logic        grant_valid;
    logic [6:0]  grant_chan;
    logic        grant_rx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_sh  [32];
    logic [31:0] m_act [32];
    int          m_idx;
    int          m_last;
    bit          m_en;

    always #5 clk = ~clk;

    slot_sched uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .adv(adv), .grant_valid(grant_valid),
        .grant_chan(grant_chan), .grant_rx(grant_rx)
    );

    function automatic bit tbl_addr_ok(logic [11:0] a);
        return (a >= 12'h800) && (a < 12'h880) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] exp_slot();
        return m_act[m_idx / 4][8 * (m_idx % 4) +: 8];
    endfunction

    function automatic logic [7:0] typ_slot(int e);
        int ch;
        ch = 2 * (e / 4) + (((e % 4) >= 2) ? 1 : 0);
        return {((e % 2) == 1) ? 1'b1 : 1'b0, 7'(ch)};
    endfunction

    task automatic model_step();
        logic [31:0] nsh [32];
        for (int w = 0; w < 32; w++) nsh[w] = m_sh[w];
        if (wr_en && tbl_addr_ok(wr_addr)) nsh[(wr_addr - 12'h800) >> 2] = wr_data;
        if (!m_en) begin
            m_idx = 0;
            for (int w = 0; w < 32; w++) m_act[w] = nsh[w];
        end else if (adv) begin
            if (m_idx >= m_last) begin
                m_idx = 0;
                for (int w = 0; w < 32; w++) m_act[w] = nsh[w];
            end else begin
                m_idx = m_idx + 1;
            end
        end
        for (int w = 0; w < 32; w++) m_sh[w] = nsh[w];
        if (wr_en && wr_addr == 12'h000) begin
            m_en   = wr_data[31];
            m_last = int'(wr_data[6:0]);
        end
    endtask

    task automatic model_check(string tag);
        logic [7:0] e;
        e = exp_slot();
        checks++;
        if (grant_valid !== m_en || (m_en && {grant_rx, grant_chan} !== e)) begin
            errors++;
            $display("FAIL %s model: got v=%0b rx=%0b ch=%0d exp v=%0b rx=%0b ch=%0d",
                     tag, grant_valid, grant_rx, grant_chan, m_en, e[7], e[6:0]);
        end
    endtask

    task automatic lit(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [8:0] g();
        return {grant_valid, grant_rx, grant_chan};
    endfunction

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        model_check(tag);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic step_n(int n, string tag);
        adv = 1'b1;
        for (int i = 0; i < n; i++) cyc(tag);
        adv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < 32; w++) begin m_sh[w] = '0; m_act[w] = '0; end
        m_idx = 0; m_last = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lit("R1 reset idle", g(), 9'h000);

        wr(12'h000, 32'h8000_0003, "R2");
        lit("R1 zero table grant", g(), {1'b1, 8'h00});
        wr(12'h000, 32'h0000_0000, "R2");
        lit("R2 disable", {8'h00, grant_valid}, 9'h000);

        // typical interleaved layout, 30 words, last index 119
        for (int w = 0; w < 30; w++)
            wr(12'(12'h800 + 4 * w),
               {typ_slot(4*w+3), typ_slot(4*w+2), typ_slot(4*w+1), typ_slot(4*w)}, "R3");
        wr(12'h000, 32'h8000_0077, "R2");
        adv = 1'b1;
        for (int e = 0; e < 120; e++) begin
            lit("R3 typical walk", g(), {1'b1, typ_slot(e)});
            cyc("R3");
        end
        adv = 1'b0;
        lit("R5 wrap after 119", g(), {1'b1, typ_slot(0)});

        repeat (3) cyc("R4");
        lit("R4 hold without adv", g(), {1'b1, typ_slot(0)});
        step_n(1, "R4");
        lit("R4 single advance", g(), {1'b1, typ_slot(1)});

        wr(12'h800, 32'h5544_3322, "R7");
        lit("R7 write hidden now", g(), {1'b1, typ_slot(1)});
        wr(12'h000, 32'h8000_0003, "R7");
        step_n(1, "R7");
        lit("R7 old pass continues", g(), {1'b1, typ_slot(2)});
        step_n(2, "R7");
        lit("R7 new pass uses write", g(), {1'b1, 8'h22});

        wr(12'h000, 32'h8000_0077, "R9");
        step_n(10, "R9");
        wr(12'h000, 32'h8000_0003, "R9");
        step_n(1, "R9");
        lit("R9 lowered last wraps", g(), {1'b1, 8'h22});

        wr(12'h000, 32'h8000_0000, "R5");
        step_n(4, "R5");
        lit("R5 last zero stays", g(), {1'b1, 8'h22});
        wr(12'h800, 32'h0000_0011, "R5");
        step_n(1, "R5");
        lit("R5 last zero reloads", g(), {1'b1, 8'h11});

        wr(12'h000, 32'h0000_0000, "R6");
        lit("R6 disabled no grant", {8'h00, grant_valid}, 9'h000);
        wr(12'h801, 32'h0000_00FF, "R8");
        wr(12'h880, 32'h0000_00EE, "R8");
        wr(12'h7FC, 32'h0000_00DD, "R8");
        wr(12'h004, 32'h8000_0005, "R8");
        lit("R8 bad ctrl addr", {8'h00, grant_valid}, 9'h000);
        wr(12'h000, 32'h8000_0000, "R8");
        lit("R8 table untouched", g(), {1'b1, 8'h11});

        wr(12'h000, 32'h8000_0077, "R6");
        step_n(5, "R6");
        wr(12'h000, 32'h0000_0077, "R6");
        wr(12'h000, 32'h8000_0077, "R6");
        lit("R6 restart at entry 0", g(), {1'b1, 8'h11});

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            adv = 1'($urandom % 2);
            if (r < 15) begin
                wr_en = 1'b1; wr_addr = 12'(12'h800 + 4 * ($urandom % 32)); wr_data = $urandom;
            end else if (r < 18) begin
                wr_en = 1'b1; wr_addr = 12'($urandom); wr_data = $urandom;
            end else if (r < 21) begin
                wr_en = 1'b1; wr_addr = 12'h000;
                wr_data = {($urandom % 8) != 0, 24'h0, ($urandom % 4 == 0) ? 7'd127 : 7'($urandom % 16)};
            end else begin
                wr_en = 1'b0;
            end
            cyc("R3 R4 R5 random");
        end
        wr_en = 1'b0; adv = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule